// File: doc/BRIEF.md
# Interrupt Vector Pin Router

This block gathers up to 256 interrupt request lines. It drives their combined state onto a small set of CPU interrupt pins. Each request line has a pending flag, which is set when the line rises, and an enable flag. The vectors are split into groups of 32, and every group is steered to one output pin by a route byte with one bit per pin.

Software reaches the block through a plain register port. Writes complete in the cycle they are issued, and reads return data one cycle later. Pending state is read, and cleared by writing ones, as 64-bit status words. If each 64-vector quarter is routed to its own pin, the handler for a pin scans one status word instead of four. If every route byte names the same pin, all vectors share that pin.

The address map is as follows. Status word i sits at byte offset 8*i, starting from 0x00. Enable register k sits at 0x40 + 4*k. Route word m sits at 0x80 + 4*m. Any other address reads as zero and ignores writes.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, every status word, enable register and route word reads as zero, and every output pin is low.
- R2: A vector's pending flag is set on a 0-to-1 transition of its input. An input held high does not set the flag again once the flag has been cleared.
- R3: Writing a status word clears the pending flags at the bit positions written as 1. Bits written as 0 leave their flags unchanged.
- R4: When a rising input and a clear of the same vector fall in the same cycle, the flag ends up set.
- R5: Status word i (offset 8*i) bit b reports the pending flag of vector 64*i+b.
- R6: Enable register k (offset 0x40+4*k) bit j enables vector 32*k+j. A pending vector that is disabled drives no pin. Setting its enable bit later asserts the pin.
- R7: Route word m (offset 0x80+4*m) byte j, where byte 0 is bits 7:0, controls group 4*m+j, which holds vectors 32*(4*m+j) to 32*(4*m+j)+31. Bit n of that byte selects output pin n.
- R8: If a route byte has more than one bit set, only its lowest set bit selects a pin.
- R9: A group whose route byte is zero drives no pin.
- R10: An output pin is high exactly when some vector is pending, enabled, and in a group routed to that pin. The pin follows the flag state with one register stage.
- R11: In single-pin mode, every route byte carries the same bit, and a vector in any quarter raises that one pin.
- R12: In multi-pin mode, bytes 0 and 1 of a route word name one pin and bytes 2 and 3 name the next pin. Each 64-vector quarter then raises its own pin of four consecutive pins.
- R13: Enable registers and route words read back the last value written, in bits 31:0, with bits 63:32 reading zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_VEC | Interrupt request lines, one per vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_rd |
| pin_out | output | NUM_PINS | Registered CPU interrupt pins |

## Verification
The hardest case to reach is a rising input and a clear of the same vector landing in one clock. The bench first captures the vector and drops its line. Then, on a single falling clock edge, it raises the line and issues the clear write, so the set and the clear meet in the same cycle. Routing corners need the same care. A route byte with several bits, a zero byte, and a disabled but pending vector can only be seen through the pins, so each one is set up while other groups stay quiet.

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
  parameter int NUM_VEC  = 256,
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_VEC-1:0]  irq_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam int GRP   = 32;
  localparam int NGRP  = NUM_VEC / GRP;
  localparam int NSTAT = NUM_VEC / 64;
  localparam int NMAP  = NGRP / 4;
  localparam logic [ADDR_W-1:0] EN_BASE  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] MAP_BASE = ADDR_W'('h80);

  logic [NUM_VEC-1:0]  irq_q, pending, enable, rise, clr;
  logic [32*NMAP-1:0]  route;
  logic [NUM_PINS-1:0] pin_d;
  logic [63:0]         rd_val;

  assign rise = irq_in & ~irq_q;

  always_comb begin
    clr = '0;
    for (int i = 0; i < NSTAT; i++)
      if (reg_wr && reg_addr == ADDR_W'(8*i)) clr[64*i +: 64] = reg_wdata;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NSTAT; i++)
      if (reg_addr == ADDR_W'(8*i)) rd_val = pending[64*i +: 64];
    for (int k = 0; k < NGRP; k++)
      if (reg_addr == EN_BASE + ADDR_W'(4*k)) rd_val = {32'd0, enable[32*k +: 32]};
    for (int m = 0; m < NMAP; m++)
      if (reg_addr == MAP_BASE + ADDR_W'(4*m)) rd_val = {32'd0, route[32*m +: 32]};
  end

  always_comb begin
    logic [7:0] rb, sel;
    pin_d = '0;
    for (int g = 0; g < NGRP; g++) begin
      rb  = route[8*g +: 8];
      sel = rb & (~rb + 8'd1);
      if (|(pending[GRP*g +: GRP] & enable[GRP*g +: GRP])) pin_d = pin_d | sel[NUM_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      pending   <= '0;
      enable    <= '0;
      route     <= '0;
      pin_out   <= '0;
      reg_rdata <= '0;
    end else begin
      irq_q   <= irq_in;
      pending <= (pending & ~clr) | rise;
      pin_out <= pin_d;
      if (reg_rd) reg_rdata <= rd_val;
      for (int k = 0; k < NGRP; k++)
        if (reg_wr && reg_addr == EN_BASE + ADDR_W'(4*k)) enable[32*k +: 32] <= reg_wdata[31:0];
      for (int m = 0; m < NMAP; m++)
        if (reg_wr && reg_addr == MAP_BASE + ADDR_W'(4*m)) route[32*m +: 32] <= reg_wdata[31:0];
    end
  end

  assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pending & $past(rise)) == $past(rise)));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((pending & ~$past(pending) & ~$past(rise)) == '0));

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & enable) == '0) |=> (pin_out == '0));

  assert_unrouted_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (route == '0) |=> (pin_out == '0));

  assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && rise == '0) |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [255:0] irq_in = '0;
  logic         reg_wr = 0, reg_rd = 0;
  logic [7:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic [7:0]   pin_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_pin_router dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_out(pin_out));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(int v);
    @(negedge clk); irq_in[v] = 1;
    @(negedge clk); irq_in[v] = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); irq_in = '0;
    for (int i = 0; i < 4; i++) wr(8'(8*i), '1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 pins", 64'(pin_out), 0);
    for (int i = 0; i < 4; i++) begin rd(8'(8*i), d); check("R1 status", d, 0); end
    rd(8'h40, d); check("R1 enable", d, 0);
    rd(8'h84, d); check("R1 route", d, 0);
  endtask

  task automatic t_capture();
    logic [63:0] d;
    for (int k = 0; k < 8; k++) wr(8'(8'h40 + 4*k), 64'hffff_ffff);
    wr(8'h80, 64'h0404_0404); wr(8'h84, 64'h0404_0404);
    @(negedge clk); irq_in[70] = 1;
    @(negedge clk);
    @(negedge clk); check("R10 R11 pin2 from vec70", 64'(pin_out), 64'h04);
    rd(8'h08, d); check("R5 R2 word1 bit6", d, 64'h40);
    wr(8'h08, 64'h0);
    rd(8'h08, d); check("R3 write zero keeps", d, 64'h40);
    wr(8'h08, 64'h40);
    rd(8'h08, d); check("R2 R3 cleared, level held", d, 0);
    check("R10 pin drops", 64'(pin_out), 0);
    pulse(10); @(negedge clk);
    check("R11 vec10 same pin", 64'(pin_out), 64'h04);
    clear_all();
  endtask

  task automatic t_setwins();
    logic [63:0] d;
    pulse(5);
    @(negedge clk); irq_in[5] = 1; reg_wr = 1; reg_addr = 8'h00; reg_wdata = 64'h20;
    @(negedge clk); reg_wr = 0;
    rd(8'h00, d); check("R4 set beats clear", d, 64'h20);
    clear_all();
    rd(8'h00, d); check("R3 clear after", d, 0);
  endtask

  task automatic t_mask();
    logic [63:0] d;
    wr(8'h40, 64'h0);
    pulse(3); @(negedge clk); @(negedge clk);
    rd(8'h00, d); check("R6 pending though masked", d, 64'h08);
    check("R6 masked no pin", 64'(pin_out), 0);
    wr(8'h40, 64'h8); @(negedge clk);
    check("R6 enable raises pin", 64'(pin_out), 64'h04);
    rd(8'h40, d); check("R13 enable readback", d, 64'h8);
    wr(8'h40, 64'hffff_ffff);
    clear_all();
  endtask

  task automatic t_multipin();
    logic [63:0] d;
    wr(8'h80, 64'h0404_0202); wr(8'h84, 64'h1010_0808);
    pulse(200); @(negedge clk);
    check("R12 R7 vec200 pin4", 64'(pin_out), 64'h10);
    rd(8'h18, d); check("R5 word3 bit8", d, 64'h100);
    pulse(100); @(negedge clk);
    check("R12 vec100 adds pin2", 64'(pin_out), 64'h14);
    rd(8'h84, d); check("R13 route readback", d, 64'h1010_0808);
    clear_all();
    pulse(130); @(negedge clk);
    check("R12 vec130 pin3", 64'(pin_out), 64'h08);
    clear_all();
  endtask

  task automatic t_lowest();
    wr(8'h80, 64'h0000_002C); wr(8'h84, 64'h0);
    pulse(7); @(negedge clk);
    check("R8 lowest bit pin2", 64'(pin_out), 64'h04);
    clear_all();
    pulse(40); @(negedge clk); @(negedge clk);
    check("R9 zero byte no pin", 64'(pin_out), 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_setwins();
    t_mask();
    t_multipin();
    t_lowest();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule